// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the Moore-style sequencer that steers a multicycle 32-bit load/store datapath built around one shared memory and one ALU. On every clock it presents a complete set of datapath steering signals: PC update enables, memory address source, memory read and write strobes, instruction register capture, register-file write controls, ALU operand selects, ALU operation class, next-PC source, and the writes into the exception PC and cause registers. The only inputs it looks at are the 6-bit opcode field held in the instruction register and the ALU overflow flag.

Every instruction starts with a fetch cycle and a decode cycle. Decode chooses a per-class path that takes one to three more cycles and then returns to fetch. The controller traps an opcode it does not recognise at decode. It also traps an overflow raised during the register-to-register execute cycle, and in that case the register write never happens. A trap cycle saves the faulting instruction's address, records a cause code and redirects the PC to a fixed vector. The current state number is also brought out so that the sequence can be observed.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high reset places the controller in state 0 (fetch) on the next rising edge. This holds even when reset arrives partway through an instruction.
- R2: State 0 drives pc_wr=1, mem_rd=1, ir_wr=1, alu_b_sel=01 and pc_src=00. Every other control output is 0, which includes alu_a_reg=0, addr_sel_alu=0 and alu_op=00. State 0 is always followed by state 1.
- R3: State 1 drives alu_b_sel=11 with alu_a_reg=0 and alu_op=00. From state 1 the next state is chosen by opcode: 100011 (load) and 101011 (store) go to state 2, 000000 (register ALU) goes to state 6, 000100 (branch on equal) goes to state 8, and 000010 (jump) goes to state 9.
- R4: State 2 drives alu_a_reg=1, alu_b_sel=10 and alu_op=00. It is followed by state 3 for a load and by state 5 for a store. State 3 drives mem_rd=1 and addr_sel_alu=1 and is followed by state 4. State 4 drives reg_wr=1, wb_from_mem=1 and dst_rd_field=0. State 5 drives mem_wr=1 and addr_sel_alu=1.
- R5: State 6 drives alu_a_reg=1, alu_b_sel=00 and alu_op=10. When no overflow is present it is followed by state 7. State 7 drives reg_wr=1, wb_from_mem=0 and dst_rd_field=1.
- R6: State 8 drives alu_a_reg=1, alu_b_sel=00, alu_op=01, pc_wr_cond=1 and pc_src=01, with pc_wr=0.
- R7: State 9 drives pc_wr=1 and pc_src=10.
- R8: The cycles from fetch back to the next fetch are 5 for a load, 4 for a store, 4 for a register ALU operation, 3 for a branch and 3 for a jump. States 4, 5, 7, 8, 9, 10 and 11 are always followed by state 0.
- R9: Any other opcode sends state 1 to state 10. State 10 drives epc_wr=1, cause_wr=1, cause_val=0, alu_a_reg=0, alu_b_sel=01, alu_op=01, pc_wr=1 and pc_src=11.
- R10: When alu_overflow=1 in state 6, the next state is 11 and not 7, so reg_wr stays 0 for that instruction. State 11 drives the same outputs as state 10 except cause_val=1. In every other state alu_overflow has no effect on the next state.
- R11: The state_num output gives the state as a 4-bit binary number. States 0 to 9 are the normal states and 10 and 11 are the two trap states.
- R12: Any control output that a state's requirement does not name is 0 in that state, and mem_rd and mem_wr are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_overflow | input | 1 | Signed overflow flag from the ALU |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by the ALU zero flag |
| addr_sel_alu | output | 1 | Memory address from ALU result register (1) or PC (0) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| wb_from_mem | output | 1 | Register write data from memory data register (1) or ALU result (0) |
| ir_wr | output | 1 | Instruction register capture |
| dst_rd_field | output | 1 | Destination register from bits 15:11 (1) or 20:16 (0) |
| reg_wr | output | 1 | Register file write enable |
| alu_a_reg | output | 1 | ALU operand A from register A (1) or PC (0) |
| alu_b_sel | output | 2 | ALU operand B: 00 reg B, 01 constant 4, 10 sign-extended immediate, 11 immediate shifted by 2 |
| alu_op | output | 2 | 00 add, 01 subtract, 10 use function field |
| pc_src | output | 2 | Next PC: 00 ALU, 01 ALU result register, 10 jump target, 11 trap vector |
| epc_wr | output | 1 | Exception PC register write |
| cause_wr | output | 1 | Cause register write |
| cause_val | output | CAUSE_W | Cause code: 0 undefined opcode, 1 overflow |
| state_num | output | 4 | Current state number |

## Verification
The bench runs each of the five legal opcodes and checks the full visited state list and the complete output word in every cycle of it. A load and a store share states up to state 2, so running both shows whether the controller takes the right branch there. Undefined opcodes are tried at the all-ones code, at codes one bit away from legal ones and at random codes, which shows whether the legal codes are decoded exactly. The overflow flag is raised in the execute cycle to confirm the trap path and the missing register write. It is also raised at random in every other cycle, where it must change nothing. A reset in the middle of a load shows that the controller returns to fetch from any state.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int OPC_W   = 6;
    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH      = 4'd0,
        ST_DECODE     = 4'd1,
        ST_MEM_ADDR   = 4'd2,
        ST_LOAD_RD    = 4'd3,
        ST_LOAD_WB    = 4'd4,
        ST_STORE_WR   = 4'd5,
        ST_ALU_EXE    = 4'd6,
        ST_ALU_WB     = 4'd7,
        ST_BRANCH     = 4'd8,
        ST_JUMP       = 4'd9,
        ST_TRAP_UNDEF = 4'd10,
        ST_TRAP_OVF   = 4'd11
    } state_e;

    typedef enum logic [2:0] {
        OC_ALU,
        OC_LOAD,
        OC_STORE,
        OC_BRANCH,
        OC_JUMP,
        OC_ILLEGAL
    } op_class_e;

    localparam logic [OPC_W-1:0] OPC_ALU    = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_JUMP   = 6'b000010;

    typedef enum logic [1:0] {
        BSEL_REG    = 2'b00,
        BSEL_FOUR   = 2'b01,
        BSEL_IMM    = 2'b10,
        BSEL_IMM_SH = 2'b11
    } bsel_e;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10,
        AOP_RSVD  = 2'b11
    } aop_e;

    typedef enum logic [1:0] {
        PSRC_ALU    = 2'b00,
        PSRC_RESULT = 2'b01,
        PSRC_JUMP   = 2'b10,
        PSRC_VECTOR = 2'b11
    } psrc_e;

    typedef struct packed {
        logic  pc_wr;
        logic  pc_wr_cond;
        logic  addr_sel_alu;
        logic  mem_rd;
        logic  mem_wr;
        logic  wb_from_mem;
        logic  ir_wr;
        logic  dst_rd_field;
        logic  reg_wr;
        logic  alu_a_reg;
        bsel_e alu_b_sel;
        aop_e  alu_op;
        psrc_e pc_src;
        logic  epc_wr;
        logic  cause_wr;
        logic  cause_ovf;
    } ctrl_t;

    localparam ctrl_t CTRL_QUIET = '0;

    function automatic op_class_e classify_opcode(input logic [OPC_W-1:0] opc);
        op_class_e cls;
        unique case (opc)
            OPC_ALU:    cls = OC_ALU;
            OPC_LOAD:   cls = OC_LOAD;
            OPC_STORE:  cls = OC_STORE;
            OPC_BRANCH: cls = OC_BRANCH;
            OPC_JUMP:   cls = OC_JUMP;
            default:    cls = OC_ILLEGAL;
        endcase
        return cls;
    endfunction

    function automatic ctrl_t trap_ctrl(input logic is_ovf);
        ctrl_t c;
        c            = CTRL_QUIET;
        c.epc_wr     = 1'b1;
        c.cause_wr   = 1'b1;
        c.cause_ovf  = is_ovf;
        c.alu_a_reg  = 1'b0;
        c.alu_b_sel  = BSEL_FOUR;
        c.alu_op     = AOP_SUB;
        c.pc_wr      = 1'b1;
        c.pc_src     = PSRC_VECTOR;
        return c;
    endfunction

endpackage

// File: rtl/mc_ctrl_classify.sv
module mc_ctrl_classify
    import mc_ctrl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output op_class_e        class_o
);

    always_comb begin
        class_o = classify_opcode(opcode_i);
    end

endmodule

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
    import mc_ctrl_pkg::*;
(
    input  state_e    state_i,
    input  op_class_e class_i,
    input  logic      overflow_i,
    output state_e    next_o
);

    always_comb begin
        next_o = ST_FETCH;
        unique case (state_i)
            ST_FETCH: next_o = ST_DECODE;
            ST_DECODE: begin
                unique case (class_i)
                    OC_LOAD,
                    OC_STORE:  next_o = ST_MEM_ADDR;
                    OC_ALU:    next_o = ST_ALU_EXE;
                    OC_BRANCH: next_o = ST_BRANCH;
                    OC_JUMP:   next_o = ST_JUMP;
                    default:   next_o = ST_TRAP_UNDEF;
                endcase
            end
            ST_MEM_ADDR: next_o = (class_i == OC_LOAD) ? ST_LOAD_RD : ST_STORE_WR;
            ST_LOAD_RD:  next_o = ST_LOAD_WB;
            ST_ALU_EXE:  next_o = overflow_i ? ST_TRAP_OVF : ST_ALU_WB;
            default:     next_o = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_outgen.sv
module mc_ctrl_outgen
    import mc_ctrl_pkg::*;
(
    input  state_e state_i,
    output ctrl_t  ctrl_o
);

    always_comb begin
        ctrl_o = CTRL_QUIET;
        unique case (state_i)
            ST_FETCH: begin
                ctrl_o.mem_rd    = 1'b1;
                ctrl_o.ir_wr     = 1'b1;
                ctrl_o.alu_b_sel = BSEL_FOUR;
                ctrl_o.alu_op    = AOP_ADD;
                ctrl_o.pc_wr     = 1'b1;
                ctrl_o.pc_src    = PSRC_ALU;
            end
            ST_DECODE: begin
                ctrl_o.alu_b_sel = BSEL_IMM_SH;
                ctrl_o.alu_op    = AOP_ADD;
            end
            ST_MEM_ADDR: begin
                ctrl_o.alu_a_reg = 1'b1;
                ctrl_o.alu_b_sel = BSEL_IMM;
                ctrl_o.alu_op    = AOP_ADD;
            end
            ST_LOAD_RD: begin
                ctrl_o.mem_rd       = 1'b1;
                ctrl_o.addr_sel_alu = 1'b1;
            end
            ST_LOAD_WB: begin
                ctrl_o.reg_wr      = 1'b1;
                ctrl_o.wb_from_mem = 1'b1;
            end
            ST_STORE_WR: begin
                ctrl_o.mem_wr       = 1'b1;
                ctrl_o.addr_sel_alu = 1'b1;
            end
            ST_ALU_EXE: begin
                ctrl_o.alu_a_reg = 1'b1;
                ctrl_o.alu_b_sel = BSEL_REG;
                ctrl_o.alu_op    = AOP_FUNCT;
            end
            ST_ALU_WB: begin
                ctrl_o.reg_wr       = 1'b1;
                ctrl_o.dst_rd_field = 1'b1;
            end
            ST_BRANCH: begin
                ctrl_o.alu_a_reg  = 1'b1;
                ctrl_o.alu_b_sel  = BSEL_REG;
                ctrl_o.alu_op     = AOP_SUB;
                ctrl_o.pc_wr_cond = 1'b1;
                ctrl_o.pc_src     = PSRC_RESULT;
            end
            ST_JUMP: begin
                ctrl_o.pc_wr  = 1'b1;
                ctrl_o.pc_src = PSRC_JUMP;
            end
            ST_TRAP_UNDEF: ctrl_o = trap_ctrl(1'b0);
            ST_TRAP_OVF:   ctrl_o = trap_ctrl(1'b1);
            default:       ctrl_o = CTRL_QUIET;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
#(
    parameter int CAUSE_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [5:0]         opcode,
    input  logic               alu_overflow,
    output logic               pc_wr,
    output logic               pc_wr_cond,
    output logic               addr_sel_alu,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               wb_from_mem,
    output logic               ir_wr,
    output logic               dst_rd_field,
    output logic               reg_wr,
    output logic               alu_a_reg,
    output logic [1:0]         alu_b_sel,
    output logic [1:0]         alu_op,
    output logic [1:0]         pc_src,
    output logic               epc_wr,
    output logic               cause_wr,
    output logic [CAUSE_W-1:0] cause_val,
    output logic [3:0]         state_num
);

    localparam int CAUSE_PAD = CAUSE_W - 1;

    state_e    state_q;
    state_e    state_d;
    op_class_e op_class;
    ctrl_t     ctrl;

    mc_ctrl_classify u_classify (
        .opcode_i (opcode),
        .class_o  (op_class)
    );

    mc_ctrl_next u_next (
        .state_i    (state_q),
        .class_i    (op_class),
        .overflow_i (alu_overflow),
        .next_o     (state_d)
    );

    mc_ctrl_outgen u_outgen (
        .state_i (state_q),
        .ctrl_o  (ctrl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    generate
        if (CAUSE_W > 1) begin : g_cause_wide
            assign cause_val = {{CAUSE_PAD{1'b0}}, ctrl.cause_ovf};
        end else begin : g_cause_narrow
            assign cause_val = ctrl.cause_ovf;
        end
    endgenerate

    assign pc_wr        = ctrl.pc_wr;
    assign pc_wr_cond   = ctrl.pc_wr_cond;
    assign addr_sel_alu = ctrl.addr_sel_alu;
    assign mem_rd       = ctrl.mem_rd;
    assign mem_wr       = ctrl.mem_wr;
    assign wb_from_mem  = ctrl.wb_from_mem;
    assign ir_wr        = ctrl.ir_wr;
    assign dst_rd_field = ctrl.dst_rd_field;
    assign reg_wr       = ctrl.reg_wr;
    assign alu_a_reg    = ctrl.alu_a_reg;
    assign alu_b_sel    = ctrl.alu_b_sel;
    assign alu_op       = ctrl.alu_op;
    assign pc_src       = ctrl.pc_src;
    assign epc_wr       = ctrl.epc_wr;
    assign cause_wr     = ctrl.cause_wr;
    assign state_num    = state_q;

    // R1: reset always lands in fetch
    a_r1_reset_to_fetch: assert property (@(posedge clk)
        rst |=> state_num == 4'd0);

    // R2: fetch is always followed by decode
    a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
        state_num == 4'd0 |=> state_num == 4'd1);

    // R4: a load read is followed by its write back
    a_r4_load_sequence: assert property (@(posedge clk) disable iff (rst)
        state_num == 4'd3 |=> state_num == 4'd4);

    // R8: terminal states return to fetch
    a_r8_terminal_return: assert property (@(posedge clk) disable iff (rst)
        (state_num == 4'd4 || state_num == 4'd5 || state_num == 4'd7 ||
         state_num == 4'd8 || state_num == 4'd9 || state_num >= 4'd10)
        |=> state_num == 4'd0);

    // R10: overflow in execute diverts to the overflow trap
    a_r10_ovf_divert: assert property (@(posedge clk) disable iff (rst)
        (state_num == 4'd6 && alu_overflow) |=> (state_num == 4'd11 && !reg_wr));

    // R10: no register write in the cycle after an overflowing execute
    a_r10_no_regwr_after_ovf: assert property (@(posedge clk) disable iff (rst)
        $past(state_num == 4'd6 && alu_overflow) |-> !reg_wr);

    // R6: conditional PC write only with the branch-target source
    a_r6_cond_source: assert property (@(posedge clk) disable iff (rst)
        pc_wr_cond |-> (pc_src == 2'b01 && !pc_wr));

    // R12: memory strobes mutually exclusive
    a_r12_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R9: a trap always writes both exception registers together with the vector
    a_r9_trap_bundle: assert property (@(posedge clk) disable iff (rst)
        epc_wr |-> (cause_wr && pc_wr && pc_src == 2'b11));

endmodule

// File: tb/mc_ctrl_fsm_tb_top.sv
`timescale 1ns/1ps
module mc_ctrl_fsm_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  opcode = 6'd0;
    logic        alu_overflow = 1'b0;
    logic        pc_wr, pc_wr_cond, addr_sel_alu, mem_rd, mem_wr, wb_from_mem;
    logic        ir_wr, dst_rd_field, reg_wr, alu_a_reg, epc_wr, cause_wr;
    logic [1:0]  alu_b_sel, alu_op, pc_src;
    logic [31:0] cause_val;
    logic [3:0]  state_num;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    int seq [6];
    int seq_len;

    always #4 clk = ~clk;

    mc_ctrl_fsm #(.CAUSE_W(32)) dut_i (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_overflow(alu_overflow),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel_alu(addr_sel_alu),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_from_mem(wb_from_mem),
        .ir_wr(ir_wr), .dst_rd_field(dst_rd_field), .reg_wr(reg_wr),
        .alu_a_reg(alu_a_reg), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
        .pc_src(pc_src), .epc_wr(epc_wr), .cause_wr(cause_wr),
        .cause_val(cause_val), .state_num(state_num)
    );

    // Field order: pc_wr pc_wr_cond addr_sel_alu mem_rd mem_wr wb_from_mem
    // ir_wr dst_rd_field reg_wr alu_a_reg alu_b_sel alu_op pc_src epc_wr cause_wr
    function automatic logic [17:0] out_word();
        return {pc_wr, pc_wr_cond, addr_sel_alu, mem_rd, mem_wr, wb_from_mem,
                ir_wr, dst_rd_field, reg_wr, alu_a_reg, alu_b_sel, alu_op,
                pc_src, epc_wr, cause_wr};
    endfunction

    function automatic logic [17:0] exp_word(input int s);
        case (s)
            0:  return {1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'b01,2'b00,2'b00,1'b0,1'b0};
            1:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,2'b00,2'b00,1'b0,1'b0};
            2:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,2'b00,2'b00,1'b0,1'b0};
            3:  return {1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,1'b0};
            4:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,2'b00,2'b00,2'b00,1'b0,1'b0};
            5:  return {1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,1'b0};
            6:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b10,2'b00,1'b0,1'b0};
            7:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,2'b00,2'b00,2'b00,1'b0,1'b0};
            8:  return {1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b01,2'b01,1'b0,1'b0};
            9:  return {1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b10,1'b0,1'b0};
            default: return {1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,2'b11,1'b1,1'b1};
        endcase
    endfunction

    function automatic string req_of(input int s);
        case (s)
            0: return "R2 R12";
            1: return "R3 R12";
            2, 3, 4, 5: return "R4 R12";
            6, 7: return "R5 R12";
            8: return "R6 R12";
            9: return "R7 R12";
            10: return "R9 R12";
            default: return "R10 R12";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected visited states from the requirements (R3, R4, R5, R6, R7, R9, R10)
    task automatic build_seq(input logic [5:0] op, input bit ovf);
        seq[0] = 0; seq[1] = 1;
        case (op)
            6'b100011: begin seq[2] = 2; seq[3] = 3; seq[4] = 4; seq_len = 5; end
            6'b101011: begin seq[2] = 2; seq[3] = 5; seq_len = 4; end
            6'b000000: begin seq[2] = 6; seq[3] = ovf ? 11 : 7; seq_len = 4; end
            6'b000100: begin seq[2] = 8; seq_len = 3; end
            6'b000010: begin seq[2] = 9; seq_len = 3; end
            default:   begin seq[2] = 10; seq_len = 3; end
        endcase
    endtask

    // Called just after a falling edge with the controller in state 0
    task automatic run_instr(input logic [5:0] op, input bit ovf);
        build_seq(op, ovf);
        opcode = op;
        for (int k = 0; k < seq_len; k++) begin
            alu_overflow = (seq[k] == 6) ? ovf : 1'($urandom % 2);
            chk("R11 state", {28'd0, state_num}, seq[k]);
            chk(req_of(seq[k]), {14'd0, out_word()}, {14'd0, exp_word(seq[k])});
            if (seq[k] >= 10)
                chk(seq[k] == 11 ? "R10 cause" : "R9 cause", cause_val, (seq[k] == 11) ? 32'd1 : 32'd0);
            else
                chk("R12 cause idle", cause_val, 32'd0);
            @(posedge clk); @(negedge clk);
        end
        chk("R8 cycle count", {28'd0, state_num}, 32'd0);
    endtask

    function automatic logic [5:0] pick_op();
        int r = $urandom % 8;
        case (r)
            0: return 6'b000000;
            1: return 6'b100011;
            2: return 6'b101011;
            3: return 6'b000100;
            4: return 6'b000010;
            default: return 6'($urandom);
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5eed_0042));
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset state", {28'd0, state_num}, 32'd0);
        chk("R1 reset outputs", {14'd0, out_word()}, {14'd0, exp_word(0)});

        // Directed: every legal class, traps and undefined near-misses
        run_instr(6'b100011, 1'b0);
        run_instr(6'b101011, 1'b0);
        run_instr(6'b000000, 1'b0);
        run_instr(6'b000000, 1'b1);
        run_instr(6'b000100, 1'b0);
        run_instr(6'b000010, 1'b0);
        run_instr(6'b111111, 1'b0);
        run_instr(6'b100010, 1'b0);
        run_instr(6'b000110, 1'b0);
        run_instr(6'b101111, 1'b0);

        // R1: reset in the middle of a load (controller in state 3)
        opcode = 6'b100011;
        repeat (3) begin @(posedge clk); @(negedge clk); end
        chk("R4 mid-load state", {28'd0, state_num}, 32'd3);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        chk("R1 reset mid-instruction", {28'd0, state_num}, 32'd0);

        // Random instruction stream
        for (int i = 0; i < 300; i++) begin
            run_instr(pick_op(), ($urandom % 4) == 0);
        end

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule